// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI slave that gives an external host read and write access to a small internal 32-bit register space. All traffic moves in 32-bit words, clock idle low, data captured on the rising edge and changed on the falling edge, most significant bit first. The first word of each frame is a command header. It holds a start address, a direction opcode, an auto-increment flag and a word count. The words after the header carry the data. For reads the bridge shifts the data out, and for writes it captures the data and commits it.

Frames are delimited by clock inactivity, not by chip select. When the serial clock has been idle for a parameterised number of system clocks, the bridge drops any partial word and waits for a new header. While that header is clocked in, it returns a fixed alternating-bit marker. This lets a host check that the card is present once it has left enough idle time. When a frame's word count has been used up, the bridge also goes back to waiting for a header by itself, so frames can follow one another with no gap.

The register space holds a few writable words at the bottom of the address map. It also holds a fixed three-word identification cookie at word addresses 0x0100 to 0x0102, which cannot be written. All other addresses read as zero. The serial inputs are brought into the system clock domain through two-flop synchronisers.

Top module: `spi_reg_bridge`

## Requirements
- R1: Each word is 32 bits, MSB first. The bridge samples MOSI on rising SCLK and updates MISO only after falling SCLK edges. The MSB of each reply word is already on MISO before the word's first rising edge.
- R2: After reset, and after every frame timeout, the reply word returned while a header is received is 0xAAAAAAAA.
- R3: If SCLK shows no edge for TIMEOUT_CYCLES system clocks, any partially received word is discarded and the next complete word is decoded as a header.
- R4: Header fields: bits 31:16 hold the start word address, bits 15:12 the opcode (0xA read, 0xB write, any other value is no operation), bit 11 the auto-increment enable, and bits 10:4 the number of data words.
- R5: In a read frame, the data words return the register contents starting at the header address. With auto-increment set, each word comes from the next higher address.
- R6: With auto-increment clear, every data word of a frame accesses the same address.
- R7: In a write frame, each complete data word is stored at the current address. The address then advances only if auto-increment is set. The reply during write data words is zero.
- R8: Addresses 0x0100, 0x0101 and 0x0102 read 0x55AACAFE, 0x54534F48 and 0x32544F4D, and writes to them have no effect.
- R9: After the last data word of a frame, the next word is decoded as a header without any timeout. A header with a count of zero, or with an unknown opcode, leaves the bridge waiting for a header, and its reply stays 0xAAAAAAAA.
- R10: Addresses 0 to NUM_REGS-1 are writable and read zero after reset. All other addresses outside the cookie read zero.
- R11: SCLK edges that arrive while CS_N is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiClk | input | 1 | Serial clock from the host, idle low |
| spiMosi | input | 1 | Serial data from the host |
| spiCsN | input | 1 | Active-low slave select |
| spiMiso | output | 1 | Serial data to the host |

## Verification
The bench goes after five corner cases.

- **Timeout resynchronisation.** It abandons a frame in the middle of a word and then sends a new header after an idle gap. A design that kept the stale bit count would decode a shifted, wrong header.
- **Chained frames.** It sends frames back to back with no idle gap. A design that needed a timeout to leave the data phase would treat the next header as data.
- **Address stepping.** It reads and writes with auto-increment both on and off. Getting the increment timing wrong shows up as the first word repeated or as an address skipped.
- **Cookie protection.** It writes to the cookie and reads it back. A design that did not protect the cookie would return the written value.
- **Chip select.** It clocks a complete write header in while chip select is high. A design that did not gate on chip select would accept that header and turn the next frame into a write.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam logic [31:0] MARKER_WORD = 32'hAAAAAAAA;

  typedef enum logic [1:0] {
    TX_MARKER = 2'd0,
    TX_READ   = 2'd1,
    TX_ZERO   = 2'd2
  } txSrcT;

  typedef enum logic {
    ST_HEADER = 1'b0,
    ST_DATA   = 1'b1
  } bridgeStateT;

  typedef struct packed {
    logic  loadTx;
    txSrcT txSrc;
    logic  regWrite;
  } strobeT;

  function automatic logic [31:0] cookieWord(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32'h55AACAFE;
      2'd1:    return 32'h54534F48;
      2'd2:    return 32'h32544F4D;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/spi_bridge_regs.sv
module spi_bridge_regs
  import spi_bridge_pkg::*;
#(
  parameter int          NUM_REGS    = 4,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] COOKIE_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);

  localparam int COOKIE_WORDS = 3;

  logic [31:0] bank [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bank[i] <= '0;
      end else if (wrEn && addr == ADDR_W'(i)) begin
        bank[i] <= wrData;
      end
    end
  end

  logic [ADDR_W-1:0] cookieOff;
  assign cookieOff = addr - ADDR_W'(COOKIE_BASE);

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rdData = bank[i];
    end
    if (addr >= ADDR_W'(COOKIE_BASE) && cookieOff < ADDR_W'(COOKIE_WORDS)) begin
      rdData = cookieWord(cookieOff[1:0]);
    end
  end

  // R8: a write aimed at the cookie leaves it unchanged on the next cycle
  assert_cookie_ro_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(COOKIE_BASE)) |=> (addr != ADDR_W'(COOKIE_BASE) || rdData == 32'h55AACAFE));

endmodule

// File: rtl/spi_bridge_datapath.sv
module spi_bridge_datapath
  import spi_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 6250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiClk,
  input  logic        spiMosi,
  input  logic        spiCsN,
  input  strobeT      strb,
  input  logic [31:0] rdData,
  output logic [31:0] rxWord,
  output logic        wordDone,
  output logic        frameTimeout,
  output logic        spiMiso
);

  localparam int              TW   = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0]   TLIM = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [TW-1:0]   TMAX = TW'(TIMEOUT_CYCLES);

  logic [1:0]    clkSync, mosiSync, csSync;
  logic          sclkPrev;
  logic          sclkRise, sclkFall, anyEdge;
  logic [TW-1:0] idleCnt;
  logic [4:0]    bitCnt;
  logic [31:0]   rxShift, txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      mosiSync <= '0;
      csSync   <= 2'b11;
      sclkPrev <= 1'b0;
    end else begin
      clkSync  <= {clkSync[0], spiClk};
      mosiSync <= {mosiSync[0], spiMosi};
      csSync   <= {csSync[0], spiCsN};
      sclkPrev <= clkSync[1];
    end
  end

  assign sclkRise = clkSync[1] & ~sclkPrev & ~csSync[1];
  assign sclkFall = ~clkSync[1] & sclkPrev & ~csSync[1];
  assign anyEdge  = sclkRise | sclkFall;

  assign frameTimeout = !anyEdge && idleCnt == TLIM;
  assign wordDone     = sclkRise && bitCnt == 5'd31;
  assign rxWord       = {rxShift[30:0], mosiSync[1]};
  assign spiMiso      = txShift[31];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (anyEdge) begin
      idleCnt <= '0;
    end else if (idleCnt != TMAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (frameTimeout) begin
      bitCnt  <= '0;
    end else if (sclkRise) begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= rxWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || frameTimeout) begin
      txShift <= MARKER_WORD;
    end else if (strb.loadTx) begin
      case (strb.txSrc)
        TX_READ: txShift <= rdData;
        TX_ZERO: txShift <= '0;
        default: txShift <= MARKER_WORD;
      endcase
    end else if (sclkFall && bitCnt != 5'd0) begin
      txShift <= {txShift[30:0], 1'b0};
    end
  end

  // R2: the marker is ready on MISO right after a frame timeout
  assert_marker_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameTimeout |=> (txShift == MARKER_WORD && bitCnt == 5'd0));

  // R11: nothing is shifted in while the slave is deselected
  assert_cs_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    csSync[1] |=> $stable(rxShift));

  // R1: MISO only moves on a falling edge or on a word load
  assert_miso_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkFall && !strb.loadTx && !frameTimeout) |=> $stable(spiMiso));

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordDone,
  input  logic              frameTimeout,
  input  logic [31:0]       rxWord,
  output strobeT            strb,
  output logic [ADDR_W-1:0] regAddr
);

  localparam int         ADDR_LSB = 16;
  localparam int         OP_LSB   = 12;
  localparam int         INC_BIT  = 11;
  localparam int         CNT_LSB  = 4;
  localparam logic [3:0] OP_READ  = 4'hA;
  localparam logic [3:0] OP_WRITE = 4'hB;

  bridgeStateT       state;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remaining;
  logic              autoInc, isWrite;

  logic [ADDR_W-1:0] hdrAddr;
  logic [3:0]        hdrOp;
  logic              hdrInc, hdrRead, hdrWrite, hdrValid;
  logic [CNT_W-1:0]  hdrCnt;

  assign hdrAddr  = rxWord[ADDR_LSB +: ADDR_W];
  assign hdrOp    = rxWord[OP_LSB +: 4];
  assign hdrInc   = rxWord[INC_BIT];
  assign hdrCnt   = rxWord[CNT_LSB +: CNT_W];
  assign hdrRead  = hdrOp == OP_READ;
  assign hdrWrite = hdrOp == OP_WRITE;
  assign hdrValid = (hdrRead || hdrWrite) && hdrCnt != '0;

  always_comb begin
    strb    = '0;
    regAddr = curAddr;
    if (wordDone) begin
      strb.loadTx = 1'b1;
      if (state == ST_HEADER) begin
        regAddr    = hdrAddr;
        strb.txSrc = !hdrValid ? TX_MARKER : (hdrRead ? TX_READ : TX_ZERO);
      end else begin
        strb.regWrite = isWrite;
        if (remaining == CNT_W'(1)) strb.txSrc = TX_MARKER;
        else if (isWrite)           strb.txSrc = TX_ZERO;
        else                        strb.txSrc = TX_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HEADER;
      curAddr   <= '0;
      remaining <= '0;
      autoInc   <= 1'b0;
      isWrite   <= 1'b0;
    end else if (frameTimeout) begin
      state <= ST_HEADER;
    end else if (wordDone) begin
      if (state == ST_HEADER) begin
        if (hdrValid) begin
          state     <= ST_DATA;
          remaining <= hdrCnt;
          autoInc   <= hdrInc;
          isWrite   <= hdrWrite;
          curAddr   <= hdrAddr + ADDR_W'(hdrRead && hdrInc);
        end
      end else begin
        remaining <= remaining - 1'b1;
        curAddr   <= curAddr + ADDR_W'(autoInc);
        if (remaining == CNT_W'(1)) state <= ST_HEADER;
      end
    end
  end

  // R3: a timeout always returns the bridge to header decoding
  assert_timeout_header_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameTimeout |=> state == ST_HEADER);

  // R9: the last data word ends the frame without a timeout
  assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && !frameTimeout && state == ST_DATA && remaining == CNT_W'(1)) |=> state == ST_HEADER);

  // R4: the data phase never runs with an exhausted count
  assert_count_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DATA |-> remaining != '0);

  // R7: writes only happen inside a write frame
  assert_write_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWrite |-> (state == ST_DATA && isWrite));

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 6250,
  parameter int NUM_REGS       = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiMosi,
  input  logic spiCsN,
  output logic spiMiso
);

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 7;

  strobeT            strb;
  logic [ADDR_W-1:0] regAddr;
  logic [31:0]       rxWord, rdData;
  logic              wordDone, frameTimeout;

  spi_bridge_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_datapath (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiMosi(spiMosi), .spiCsN(spiCsN),
    .strb(strb), .rdData(rdData), .rxWord(rxWord), .wordDone(wordDone),
    .frameTimeout(frameTimeout), .spiMiso(spiMiso)
  );

  spi_bridge_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordDone(wordDone), .frameTimeout(frameTimeout),
    .rxWord(rxWord), .strb(strb), .regAddr(regAddr)
  );

  spi_bridge_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .addr(regAddr), .wrEn(strb.regWrite),
    .wrData(rxWord), .rdData(rdData)
  );

endmodule

// File: tb/spi_reg_bridge_tb.sv
module spi_reg_bridge_tb;

  localparam int TIMEOUT = 200;
  localparam int HALF    = 8;
  localparam int ROWS    = 11;
  localparam logic [31:0] MK = 32'hAAAAAAAA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic spiMosi = 1'b0;
  logic spiCsN = 1'b0;
  logic spiMiso;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_reg_bridge #(.TIMEOUT_CYCLES(TIMEOUT), .NUM_REGS(4)) u_dut (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiMosi(spiMosi),
    .spiCsN(spiCsN), .spiMiso(spiMiso)
  );

  // Frames sent back to back with no idle gap (R9 chaining throughout)
  localparam logic [31:0] TMOSI [ROWS][4] = '{
    '{32'h0000B820, 32'h11111111, 32'h22222222, 32'h0},        // R7 write inc
    '{32'h0100A830, 32'h0, 32'h0, 32'h0},                      // R8 R5 cookie
    '{32'h0000A820, 32'h0, 32'h0, 32'h0},                      // R5 read inc
    '{32'h0001A020, 32'h0, 32'h0, 32'h0},                      // R6 no inc
    '{32'h0100B010, 32'hDEADBEEF, 32'h0, 32'h0},               // R8 write cookie
    '{32'h0100A010, 32'h0, 32'h0, 32'h0},                      // R8 readback
    '{32'h0003B020, 32'h00000033, 32'h00000044, 32'h0},        // R7 no inc
    '{32'h0003A010, 32'h0, 32'h0, 32'h0},                      // R7 readback
    '{32'h0200A010, 32'h0, 32'h0, 32'h0},                      // R10 unmapped
    '{32'h0000A000, 32'h0, 32'h0, 32'h0},                      // R9 zero count
    '{32'h0102A010, 32'h0, 32'h0, 32'h0}                       // R4 R8 last cookie
  };
  localparam logic [31:0] TEXP [ROWS][4] = '{
    '{MK, 32'h0, 32'h0, 32'h0},
    '{MK, 32'h55AACAFE, 32'h54534F48, 32'h32544F4D},
    '{MK, 32'h11111111, 32'h22222222, 32'h0},
    '{MK, 32'h22222222, 32'h22222222, 32'h0},
    '{MK, 32'h0, 32'h0, 32'h0},
    '{MK, 32'h55AACAFE, 32'h0, 32'h0},
    '{MK, 32'h0, 32'h0, 32'h0},
    '{MK, 32'h00000044, 32'h0, 32'h0},
    '{MK, 32'h0, 32'h0, 32'h0},
    '{MK, 32'h0, 32'h0, 32'h0},
    '{MK, 32'h32544F4D, 32'h0, 32'h0}
  };
  localparam int TN   [ROWS] = '{3, 4, 3, 3, 2, 2, 3, 2, 2, 1, 2};
  localparam int TREQ [ROWS] = '{7, 5, 5, 6, 8, 8, 7, 7, 10, 9, 4};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spiBits(input logic [31:0] w, input int n, output logic [31:0] r);
    r = '0;
    for (int b = 31; b > 31 - n; b--) begin
      spiMosi = w[b];
      repeat (HALF) @(negedge clk);
      r[b] = spiMiso;
      spiClk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiClk = 1'b0;
    end
  endtask

  task automatic spiWord(input logic [31:0] w, output logic [31:0] r);
    spiBits(w, 32, r);
  endtask

  task automatic idleTimeout();
    repeat (TIMEOUT + 40) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R2: marker MSB present on MISO out of reset
    chk({31'b0, spiMiso}, 32'h1, "R2 reset miso");

    // R10: writable word reads zero after reset; R1 MSB-first reply
    spiWord(32'h0002A010, r); chk(r, MK, "R2 reset header reply");
    spiWord(32'h0, r);        chk(r, 32'h0, "R10 reset reg value");

    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < TN[i]; j++) begin
        spiWord(TMOSI[i][j], r);
        chk(r, TEXP[i][j], $sformatf("R%0d row %0d word %0d", TREQ[i], i, j));
      end
    end

    // R3: abandon a word mid-way, then resynchronise on timeout
    spiBits(32'h0000B810, 10, r);
    idleTimeout();
    chk({31'b0, spiMiso}, 32'h1, "R3 miso after timeout");
    spiWord(32'h0101A010, r); chk(r, MK, "R3 R2 header after timeout");
    spiWord(32'h0, r);        chk(r, 32'h54534F48, "R3 data after timeout");

    // R11: a write header clocked while deselected must be ignored
    spiCsN = 1'b1;
    repeat (4) @(negedge clk);
    spiWord(32'h0000B010, r);
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    spiWord(32'h0000A010, r); chk(r, MK, "R11 header after deselect");
    spiWord(32'h0, r);        chk(r, 32'h11111111, "R11 reg0 untouched");

    // R9: unknown opcode keeps header decoding, marker reply
    spiWord(32'h0000C010, r); chk(r, MK, "R9 bad opcode reply");
    spiWord(32'h0001A010, r); chk(r, MK, "R9 header after bad opcode");
    spiWord(32'h0, r);        chk(r, 32'h22222222, "R9 data after bad opcode");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule